// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs a single raw operation on an 8-bit asynchronous NAND bus. Software loads an opcode pair, the address bytes, a byte count and the strobe timing through a small register port. It then writes an operation word. That word holds one enable bit for each bus phase, the chip to select and the number of address cycles. The engine runs only the enabled phases, always in the same fixed order: first command, address, write data, second command, wait for ready, read data. It drives the chip enables, the command and address latch enables and the two data strobes. Each strobe has a programmable low time and a shared high time.

One 16-entry byte buffer serves both data directions. Software fills the buffer before a write-data phase. A read-data phase captures bytes into the buffer, which software reads back afterwards through the same register port. A status bit tells software when the engine is idle again, and this includes any wait for the device's ready/busy line.

Top module: `nand_op_seq`

## Requirements
- R1: After reset, all chip enables and both strobes are high, CLE and ALE are low, the data bus is not driven, status bit 0 reads 1, and the timing register (index 5) reads 0x375. Its fields are write-low in bits 3:0, read-low in bits 7:4 and high time in bits 11:8.
- R2: The operation word (index 4) has these enables: first command at bit 6, address at bit 5, write data at bit 4, second command at bit 3, wait-ready at bit 2 and read data at bit 1. The enabled phases run in that order, and a disabled phase produces no bus cycle.
- R3: The command register (index 0) gives the first opcode in bits 7:0 and the second in bits 15:8. CLE is high only on command cycles and ALE is high only on address cycles, and the two are never high together.
- R4: The operation word bits 11:9 set the number of address cycles. These are sent in order: byte k comes from bits 8k+7:8k of the low address register (index 1) for k = 0..3, and byte 4 comes from bits 7:0 of the high register (index 2).
- R5: On every bus cycle, WE# stays low for the write-low count and RE# stays low for the read-low count, then the strobe stays high for the high count (all in clocks). A field value of 0 acts as 1. WE# and RE# are never low together, and the data bus is driven throughout each write cycle.
- R6: Operation word bits 8:7 pick one of four chip enables. Only that CE# goes low, and it stays low without change from the operation's first cycle to its last.
- R7: R/B# passes through a two-flop synchronizer. In the wait phase the engine holds for a short guard time and then until ready is seen, so the operation does not end while R/B# is low.
- R8: Status bit 0 (index 6) reads 1 only when the engine is idle with its operation complete, and the bus is idle whenever it reads 1.
- R9: The count register (index 3) sets how many bytes a data phase moves, and values above 16 are held at 16. Each read byte is captured on the rising edge of RE# into buffer entries 0, 1, … in turn. Buffer entry i is read at index 16+i, in bits 7:0, and entries past the count keep their value.
- R10: A write-data phase sends buffer entries 0 to count−1 in order. Software writes entry i at index 16+i while the engine is idle.
- R11: A write to the operation word while the engine is busy is ignored: the running operation is unchanged, and the operation register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register index; 16..31 select buffer entries |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| nand_ce_n | output | NUM_CS | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus input value |
| nand_rb_n | input | 1 | Ready (1) / busy (0) from the device |

## Verification
On every cycle, the assertions check the bus rules that have to hold at all times. These are: the latch enables and the strobes are mutually exclusive, at most one CE# is low and it does not change during an operation, the bus is quiet while the engine reports ready, the data bus is driven under WE# low, and each read capture is followed by an RE# rising edge. Other behaviour is visible only in the bench's scenarios: the order and content of the bus cycles for each mix of enabled phases, the address byte packing, the exact strobe widths for several timing settings, the buffer contents after reads, the hold during a device busy period and the ignored busy-time write.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    PH_CMD1  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_WDATA = 3'd2,
    PH_CMD2  = 3'd3,
    PH_WAIT  = 3'd4,
    PH_RDATA = 3'd5,
    PH_IDLE  = 3'd6
  } phase_t;

  // operation word bit positions
  localparam int OPB_RDATA = 1;
  localparam int OPB_WAIT  = 2;
  localparam int OPB_CMD2  = 3;
  localparam int OPB_WDATA = 4;
  localparam int OPB_ADDR  = 5;
  localparam int OPB_CMD1  = 6;
  localparam int OPB_CS    = 7;
  localparam int OPB_ACYC  = 9;

  // register indices
  localparam logic [4:0] A_CMD  = 5'd0;
  localparam logic [4:0] A_ALO  = 5'd1;
  localparam logic [4:0] A_AHI  = 5'd2;
  localparam logic [4:0] A_CNT  = 5'd3;
  localparam logic [4:0] A_OP   = 5'd4;
  localparam logic [4:0] A_TIM  = 5'd5;
  localparam logic [4:0] A_STAT = 5'd6;

  localparam logic [11:0] TIM_RESET = 12'h375;

  // a zero timing field still yields one clock
  function automatic logic [3:0] pulse_len(input logic [3:0] w);
    return (w == 4'd0) ? 4'd1 : w;
  endfunction

  function automatic logic [7:0] addr_byte(input logic [31:0] lo, input logic [7:0] hi,
                                           input logic [2:0] k);
    case (k)
      3'd0:    return lo[7:0];
      3'd1:    return lo[15:8];
      3'd2:    return lo[23:16];
      3'd3:    return lo[31:24];
      3'd4:    return hi;
      default: return 8'h00;
    endcase
  endfunction

  // one bit per phase in run order; a phase with nothing to move is dropped
  function automatic logic [5:0] run_mask(input logic [11:0] op, input logic have_data);
    return {op[OPB_RDATA] & have_data, op[OPB_WAIT], op[OPB_CMD2],
            op[OPB_WDATA] & have_data, op[OPB_ADDR] & (op[11:9] != 3'd0), op[OPB_CMD1]};
  endfunction

  function automatic phase_t next_phase(input logic [5:0] mask, input logic [2:0] from);
    phase_t p;
    p = PH_IDLE;
    for (int i = 5; i >= 0; i--)
      if (mask[i] && (3'(i) >= from)) p = phase_t'(3'(i));
    return p;
  endfunction

endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sr_q <= '1;
    else        sr_q <= {sr_q[STAGES-2:0], async_in};

  assign sync_out = sr_q[STAGES-1];
endmodule

// File: rtl/nand_byte_buf.sv
module nand_byte_buf #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_idx_a,
  output logic [7:0]    rd_data_a,
  input  logic [AW-1:0] rd_idx_b,
  output logic [7:0]    rd_data_b
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else if (wr_en) begin
      mem_q[wr_idx] <= wr_data;
    end

  assign rd_data_a = mem_q[rd_idx_a];
  assign rd_data_b = mem_q[rd_idx_b];
endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
  import nand_seq_pkg::*;
#(
  parameter int BUF_DEPTH   = 16,
  parameter int NUM_CS      = 4,
  parameter int GUARD_CYC   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NUM_CS-1:0] nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [7:0]        nand_dq_in,
  input  logic              nand_rb_n
);
  localparam int BUF_AW = $clog2(BUF_DEPTH);
  localparam int CNT_W  = BUF_AW + 1;
  localparam int CS_W   = $clog2(NUM_CS);
  localparam logic [3:0] GUARD_END = 4'(GUARD_CYC - 1);

  function automatic logic [CNT_W-1:0] clamp_count(input logic [31:0] w);
    return (w > 32'(BUF_DEPTH)) ? CNT_W'(BUF_DEPTH) : w[CNT_W-1:0];
  endfunction

  // programmed state
  logic [15:0]      cmd_q;
  logic [31:0]      alo_q;
  logic [7:0]       ahi_q;
  logic [CNT_W-1:0] dnum_q;
  logic [11:0]      op_q;
  logic [11:0]      tim_q;

  // sequencing state
  phase_t           phase_q;
  logic             high_q;
  logic [3:0]       tcnt_q;
  logic [CNT_W-1:0] bcnt_q;

  // named events, also used by the checker
  logic op_ready, op_start, rd_capture, strobe_end, last_byte, sw_buf_wr, rb_ready;
  logic is_cmd, is_wr;
  logic [5:0]       mask_now;
  logic [3:0]       low_len, high_len;
  logic [CNT_W-1:0] phase_bytes;
  logic [7:0]       out_byte, buf_rd_sw, buf_rd_eng;
  logic             unused_wdata_bits;

  assign unused_wdata_bits = &reg_wdata[31:16];

  assign op_ready   = (phase_q == PH_IDLE);
  assign op_start   = reg_wr && (reg_addr == A_OP) && op_ready;
  assign sw_buf_wr  = reg_wr && reg_addr[4] && op_ready;
  assign mask_now   = run_mask(op_q, dnum_q != '0);
  assign low_len    = pulse_len((phase_q == PH_RDATA) ? tim_q[7:4] : tim_q[3:0]);
  assign high_len   = pulse_len(tim_q[11:8]);
  assign strobe_end = (tcnt_q == ((high_q ? high_len : low_len) - 4'd1));
  assign rd_capture = (phase_q == PH_RDATA) && !high_q && strobe_end;
  assign last_byte  = (bcnt_q == phase_bytes - CNT_W'(1));

  always_comb begin
    case (phase_q)
      PH_CMD1, PH_CMD2: phase_bytes = CNT_W'(1);
      PH_ADDR:          phase_bytes = CNT_W'(op_q[11:9]);
      default:          phase_bytes = dnum_q;
    endcase
  end

  always_comb begin
    case (phase_q)
      PH_CMD1:  out_byte = cmd_q[7:0];
      PH_CMD2:  out_byte = cmd_q[15:8];
      PH_ADDR:  out_byte = addr_byte(alo_q, ahi_q, bcnt_q[2:0]);
      PH_WDATA: out_byte = buf_rd_eng;
      default:  out_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      alo_q   <= '0;
      ahi_q   <= '0;
      dnum_q  <= '0;
      op_q    <= '0;
      tim_q   <= TIM_RESET;
      phase_q <= PH_IDLE;
      high_q  <= 1'b0;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_CMD:   cmd_q  <= reg_wdata[15:0];
          A_ALO:   alo_q  <= reg_wdata;
          A_AHI:   ahi_q  <= reg_wdata[7:0];
          A_CNT:   dnum_q <= clamp_count(reg_wdata);
          A_TIM:   tim_q  <= reg_wdata[11:0];
          default: ;
        endcase
      end
      if (op_start) begin
        op_q    <= reg_wdata[11:0];
        phase_q <= next_phase(run_mask(reg_wdata[11:0], dnum_q != '0), 3'd0);
        high_q  <= 1'b0;
        tcnt_q  <= '0;
        bcnt_q  <= '0;
      end else if (phase_q == PH_WAIT) begin
        if (tcnt_q != GUARD_END) tcnt_q <= tcnt_q + 4'd1;
        else if (rb_ready) begin
          tcnt_q  <= '0;
          phase_q <= next_phase(mask_now, 3'd5);
        end
      end else if (phase_q != PH_IDLE) begin
        if (!strobe_end) tcnt_q <= tcnt_q + 4'd1;
        else begin
          tcnt_q <= '0;
          high_q <= !high_q;
          if (high_q) begin
            if (last_byte) begin
              bcnt_q  <= '0;
              phase_q <= next_phase(mask_now, 3'(phase_q) + 3'd1);
            end else begin
              bcnt_q <= bcnt_q + CNT_W'(1);
            end
          end
        end
      end
    end
  end

  // bus pins
  assign is_cmd      = (phase_q == PH_CMD1) || (phase_q == PH_CMD2);
  assign is_wr       = is_cmd || (phase_q == PH_ADDR) || (phase_q == PH_WDATA);
  assign nand_cle    = is_cmd;
  assign nand_ale    = (phase_q == PH_ADDR);
  assign nand_we_n   = !(is_wr && !high_q);
  assign nand_re_n   = !((phase_q == PH_RDATA) && !high_q);
  assign nand_dq_oe  = is_wr;
  assign nand_dq_out = is_wr ? out_byte : 8'h00;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_ce
    assign nand_ce_n[g] = !(!op_ready && (op_q[OPB_CS +: CS_W] == CS_W'(g)));
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[4]) reg_rdata[7:0] = buf_rd_sw;
    else begin
      case (reg_addr)
        A_CMD:   reg_rdata[15:0]      = cmd_q;
        A_ALO:   reg_rdata            = alo_q;
        A_AHI:   reg_rdata[7:0]       = ahi_q;
        A_CNT:   reg_rdata[CNT_W-1:0] = dnum_q;
        A_OP:    reg_rdata[11:0]      = op_q;
        A_TIM:   reg_rdata[11:0]      = tim_q;
        A_STAT:  reg_rdata[0]         = op_ready;
        default: ;
      endcase
    end
  end

  nand_rb_sync #(.STAGES(SYNC_STAGES)) u_rb_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (nand_rb_n),
    .sync_out (rb_ready)
  );

  nand_byte_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (rd_capture || sw_buf_wr),
    .wr_idx    (rd_capture ? bcnt_q[BUF_AW-1:0] : reg_addr[BUF_AW-1:0]),
    .wr_data   (rd_capture ? nand_dq_in : reg_wdata[7:0]),
    .rd_idx_a  (reg_addr[BUF_AW-1:0]),
    .rd_data_a (buf_rd_sw),
    .rd_idx_b  (bcnt_q[BUF_AW-1:0]),
    .rd_data_b (buf_rd_eng)
  );
endmodule

// File: rtl/nand_op_seq_chk.sv
module nand_op_seq_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CS-1:0] nand_ce_n,
  input logic              nand_cle,
  input logic              nand_ale,
  input logic              nand_we_n,
  input logic              nand_re_n,
  input logic              nand_dq_oe,
  input logic              op_ready,
  input logic              rd_capture
);
  assert_latch_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  assert_latch_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_cle || nand_ale) |-> (nand_dq_oe && nand_re_n));

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  assert_drive_under_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe);

  assert_single_ce_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~nand_ce_n) <= 1);

  assert_ce_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_ready && $past(!op_ready)) |-> $stable(nand_ce_n));

  assert_quiet_when_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> (&nand_ce_n && nand_we_n && nand_re_n && !nand_dq_oe));

  assert_capture_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |=> $rose(nand_re_n));
endmodule

bind nand_op_seq nand_op_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .nand_ce_n  (nand_ce_n),
  .nand_cle   (nand_cle),
  .nand_ale   (nand_ale),
  .nand_we_n  (nand_we_n),
  .nand_re_n  (nand_re_n),
  .nand_dq_oe (nand_dq_oe),
  .op_ready   (op_ready),
  .rd_capture (rd_capture)
);

// File: tb/nand_op_seq_bench.sv
module nand_op_seq_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        reg_wr;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  nand_ce_n;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out, nand_dq_in;
  logic        rb_n;

  int checks = 0;
  int errors = 0;
  logic [9:0] exp_q[$];
  int exp_wlo = 5, exp_rlo = 7;
  logic [3:0] exp_ce = 4'hF;
  int busy_len = 0, busy_ctr = 0;
  int re_cnt = 0, re_base = 0;
  logic [7:0] rd_base = 8'h00;
  int wlow = 0, rlow = 0;
  logic prev_we = 1'b1, prev_re = 1'b1;

  assign nand_dq_in = rd_base + 8'(re_cnt - re_base);

  nand_op_seq u_nand_op_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rb_n(rb_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: bus cycles against the scoreboard, strobe widths, device model
  always @(negedge clk) begin
    if (!rst_n) begin
      rb_n = 1'b1; busy_ctr = 0; wlow = 0; rlow = 0; prev_we = 1'b1; prev_re = 1'b1;
    end else begin
      if (busy_ctr > 0) begin
        busy_ctr--;
        if (busy_ctr == 0) begin
          rb_n = 1'b1;
          check("R7 op still open at busy release", {28'h0, nand_ce_n}, {28'h0, exp_ce});
        end
      end
      if (!nand_we_n) wlow++;
      else if (!prev_we) begin
        logic [9:0] got;
        got = {nand_cle ? 2'd1 : (nand_ale ? 2'd2 : 2'd3), nand_dq_out};
        check("R5 WE# low width", wlow, exp_wlo);
        check("R6 chip enable", {28'h0, nand_ce_n}, {28'h0, exp_ce});
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 unexpected bus cycle: actual %h expected none", got);
        end else begin
          check("R2 R3 R4 R10 bus cycle", {22'h0, got}, {22'h0, exp_q.pop_front()});
        end
        if (nand_cle && nand_dq_out == 8'hD0 && busy_len > 0) begin
          rb_n = 1'b0; busy_ctr = busy_len;
        end
        wlow = 0;
      end
      if (!nand_re_n) rlow++;
      else if (!prev_re) begin
        check("R5 RE# low width", rlow, exp_rlo);
        re_cnt++;
        rlow = 0;
      end
      prev_we = nand_we_n;
      prev_re = nand_re_n;
    end
  end

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wr = 1'b0;
    #1 d = reg_rdata;
  endtask

  task automatic push(input logic [1:0] kind, input logic [7:0] b);
    exp_q.push_back({kind, b});
  endtask

  function automatic logic [31:0] make_op(input bit c1, input bit ad, input bit wd,
      input bit c2, input bit wt, input bit rd, input int cs, input int acyc);
    logic [31:0] w;
    w = 32'(acyc) * 512 + 32'(cs) * 128;
    if (c1) w += 64;
    if (ad) w += 32;
    if (wd) w += 16;
    if (c2) w += 8;
    if (wt) w += 4;
    if (rd) w += 2;
    return w;
  endfunction

  task automatic wait_ready(input string req);
    logic [31:0] s;
    s = 0;
    for (int i = 0; i < 5000; i++) begin
      rd_reg(5'd6, s);
      if (s[0]) break;
    end
    check(req, s & 32'h1, 32'h1);
    check("R2 scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] op;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 chip enables", {28'h0, nand_ce_n}, 32'hF);
    check("R1 strobes/latches", {28'h0, nand_we_n, nand_re_n, nand_cle, nand_ale}, 32'hC);
    check("R1 bus drive", {31'h0, nand_dq_oe}, 32'h0);
    rd_reg(5'd6, d); check("R1 R8 status ready", d, 32'h1);
    rd_reg(5'd5, d); check("R1 timing default", d, 32'h375);

    // ID-style read: cmd, one address, 16 data bytes, chip 1
    exp_wlo = 5; exp_rlo = 7; exp_ce = 4'b1101;
    wr_reg(5'd0, 32'h0090);
    wr_reg(5'd1, 32'h0);
    wr_reg(5'd3, 32'd16);
    rd_base = 8'h30; re_base = re_cnt;
    push(2'd1, 8'h90); push(2'd2, 8'h00);
    wr_reg(5'd4, make_op(1, 1, 0, 0, 0, 1, 1, 1));
    rd_reg(5'd6, d); check("R8 status busy during op", d & 32'h1, 32'h0);
    wait_ready("R8 ready after 16-byte read");
    for (int i = 0; i < 16; i++) begin
      rd_reg(5'(16 + i), d);
      check("R9 captured byte", d, 32'(8'h30 + 8'(i)));
    end

    // erase-style: cmd1, 3 address cycles, cmd2, wait for ready, chip 2
    exp_ce = 4'b1011; busy_len = 30;
    wr_reg(5'd0, 32'hD060);
    wr_reg(5'd1, 32'h0056_3412);
    push(2'd1, 8'h60); push(2'd2, 8'h12); push(2'd2, 8'h34); push(2'd2, 8'h56);
    push(2'd1, 8'hD0);
    wr_reg(5'd4, make_op(1, 1, 0, 1, 1, 0, 2, 3));
    wait_ready("R7 R8 ready after busy wait");
    busy_len = 0;

    // program-style: 5 address cycles, 4 data bytes from buffer, chip 3, short timing
    wr_reg(5'd5, 32'h112); exp_wlo = 2; exp_rlo = 1;
    for (int i = 0; i < 4; i++) wr_reg(5'(16 + i), 32'(8'hC1 + 8'(i)));
    wr_reg(5'd3, 32'd4);
    wr_reg(5'd0, 32'h1080);
    wr_reg(5'd1, 32'h4433_2211);
    wr_reg(5'd2, 32'h55);
    exp_ce = 4'b0111;
    push(2'd1, 8'h80);
    push(2'd2, 8'h11); push(2'd2, 8'h22); push(2'd2, 8'h33); push(2'd2, 8'h44); push(2'd2, 8'h55);
    for (int i = 0; i < 4; i++) push(2'd3, 8'hC1 + 8'(i));
    push(2'd1, 8'h10);
    op = make_op(1, 1, 1, 1, 0, 0, 3, 5);
    wr_reg(5'd4, op);
    wr_reg(5'd4, make_op(1, 0, 0, 0, 0, 0, 0, 0));  // busy: must be ignored (R11)
    wait_ready("R10 ready after write data");
    repeat (20) @(negedge clk);
    check("R11 no extra cycles after ignored write", exp_q.size(), 0);
    rd_reg(5'd4, d); check("R11 op register unchanged", d, op);

    // status-style read of one byte, zero timing fields act as 1, chip 0
    wr_reg(5'd5, 32'h000); exp_wlo = 1; exp_rlo = 1; exp_ce = 4'b1110;
    wr_reg(5'd3, 32'd1);
    wr_reg(5'd0, 32'h0070);
    rd_base = 8'hE0; re_base = re_cnt;
    push(2'd1, 8'h70);
    wr_reg(5'd4, make_op(1, 0, 0, 0, 0, 1, 0, 0));
    wait_ready("R5 R8 ready after minimal timing read");
    rd_reg(5'd16, d); check("R9 single captured byte", d, 32'hE0);
    rd_reg(5'd17, d); check("R9 entry past count untouched", d, 32'hC2);

    // count clamp
    wr_reg(5'd3, 32'd40);
    rd_reg(5'd3, d); check("R9 count clamped", d, 32'd16);

    summary();
  end
endmodule